// File: doc/BRIEF.md
# CEC Receive Bit-Timing Checker

This block sits behind the glitch filter of an HDMI-CEC receiver. It watches the filtered bus line, which idles high. It counts microsecond ticks from each falling edge and measures two things for every bit: the low time, ending at the rising edge, and the full bit period, ending at the next falling edge. It first recognises a start bit. After that it classifies each data bit as logic 0 or logic 1 from its low time. Reception ends at the close of the message, or earlier when a timing error stops it.

Two timing faults are reported. A rising error means the low time of a data bit fits neither data window, or the line stays low past the longest legal low time. A long-period error means the line does not fall again before the late limit of the period window. The block also decides whether an error bit should be driven on the bus. That decision depends on three enable inputs and on whether the message is broadcast. The error-bit driver, byte assembly and acknowledge logic live in neighbouring blocks.

Two window sets exist, normal and extended. The selection is sampled only while the block is disabled. All nominal times and tolerances are parameters in microsecond ticks.

Top module: `cec_rx_bit_timing`

## Requirements
- R1: A start bit is accepted when its low time is within 3500..3900 ticks and its period within 4300..4700 ticks (normal set). Acceptance gives a one-cycle `sof_o` pulse at the falling edge that ends the start bit. A start candidate outside these windows produces no output, and the next falling edge begins a new start candidate.
- R2: After a start bit, a data bit whose low time is within 1300..1700 ticks gives a one-cycle `bit_valid_o` pulse with `bit_o`=0. A low time within 400..800 gives the pulse with `bit_o`=1. The pulse follows the rising edge. `bit_o` is 0 whenever `bit_valid_o` is 0.
- R3: A data-bit rising edge outside both data windows gives a one-cycle `bre_o` pulse. A line held low beyond 1700 ticks also gives the pulse, without waiting for the rise. No bit is output for that data bit.
- R4: With `stop_on_bre_i`=1, a rising error also pulses `stop_rx_o` in the same cycle and ends the message, so the next falling edge is treated as a start candidate. With `stop_on_bre_i`=0, decoding continues with the following data bit.
- R5: If no falling edge arrives within 2750 ticks after a data bit began, `lbpe_o` pulses and the message ends. When `last_bit_i`=1 at that moment, the message ends without any pulse.
- R6: With the extended set, the windows become: start low 3300..4100, start period 4100..4900, data low 1200..1800 or 300..900, data period 1900..2900.
- R7: `ext_tol_i` (1 = extended) is captured only while `en_i`=0. Changes made while enabled have no effect on the windows.
- R8: For a non-broadcast message (`bcast_i`=0), `err_req_o` pulses together with a rising error when `bre_gen_i`=1. It pulses together with a long-period error when `lbpe_gen_i`=1. It does not pulse otherwise.
- R9: For a broadcast message with `bcast_nogen_i`=0, `err_req_o` pulses with every long-period error. It pulses with a rising error when `bre_gen_i`=1 or `stop_on_bre_i`=1.
- R10: For a broadcast message with `bcast_nogen_i`=1, `err_req_o` never pulses.
- R11: While `en_i`=0 no output pulses, and at most one of `sof_o`, `bit_valid_o`, `bre_o`, `lbpe_o` is high in any cycle.
- R12: After reset all outputs are 0, and the normal window set is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| tick_i | input | 1 | One-cycle microsecond tick |
| line_i | input | 1 | Filtered bus level, high when idle |
| ext_tol_i | input | 1 | 1 selects extended windows (captured while disabled) |
| stop_on_bre_i | input | 1 | End the message on a rising error |
| bre_gen_i | input | 1 | Error bit on rising error |
| lbpe_gen_i | input | 1 | Error bit on long-period error |
| bcast_nogen_i | input | 1 | Suppress error bits in broadcast messages |
| bcast_i | input | 1 | Current message is broadcast |
| last_bit_i | input | 1 | Current data bit is the final bit of the message |
| sof_o | output | 1 | Start bit accepted |
| bit_valid_o | output | 1 | Data bit decoded |
| bit_o | output | 1 | Decoded data value |
| bre_o | output | 1 | Bit rising error |
| lbpe_o | output | 1 | Long bit period error |
| stop_rx_o | output | 1 | Reception stopped by a rising error |
| err_req_o | output | 1 | Request to drive an error bit |

## Verification
The hardest case to reach from the ports is a rising error raised by a line stuck low. The fault is flagged by a timer while the rising edge has not yet occurred, and the later rise must then be absorbed without a second flag. The stimulus holds a data bit low for 2000 ticks with stop enabled, then checks that exactly one error event arrives and the line returns quietly to idle. The tolerance latch is also hard to reach. It is exercised with a start bit that is legal only in the extended set, sent once after the selection input changes while enabled and once after a disable/enable cycle.

// File: rtl/cec_rxt_pkg.sv
package cec_rxt_pkg;
  localparam int unsigned TICK_W = 14;
  typedef logic [TICK_W-1:0] tick_t;

  typedef struct packed {
    tick_t sb_low_lo, sb_low_hi;
    tick_t sb_per_lo, sb_per_hi;
    tick_t d0_lo, d0_hi;
    tick_t d1_lo, d1_hi;
    tick_t per_lo, per_hi;
  } win_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SB_LOW, ST_SB_HIGH, ST_DB_LOW, ST_DB_HIGH, ST_WAIT_HIGH
  } st_e;

  typedef struct packed {
    logic sof;
    logic bitv;
    logic bitval;
    logic bre;
    logic lbpe;
    logic stop;
  } ev_t;

  function automatic win_t make_win(int sb_low, int sb_per, int d0, int d1, int per,
                                    int t_sb, int t_rise, int t_fall);
    win_t w;
    w.sb_low_lo = tick_t'(sb_low - t_sb);
    w.sb_low_hi = tick_t'(sb_low + t_sb);
    w.sb_per_lo = tick_t'(sb_per - t_sb);
    w.sb_per_hi = tick_t'(sb_per + t_sb);
    w.d0_lo     = tick_t'(d0 - t_rise);
    w.d0_hi     = tick_t'(d0 + t_rise);
    w.d1_lo     = tick_t'(d1 - t_rise);
    w.d1_hi     = tick_t'(d1 + t_rise);
    w.per_lo    = tick_t'(per - t_fall);
    w.per_hi    = tick_t'(per + t_fall);
    return w;
  endfunction

  function automatic logic in_win(tick_t v, tick_t lo, tick_t hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/cec_rxt_win.sv
module cec_rxt_win
  import cec_rxt_pkg::*;
#(
  parameter int SB_LOW_NOM  = 3700,
  parameter int SB_PER_NOM  = 4500,
  parameter int D0_LOW_NOM  = 1500,
  parameter int D1_LOW_NOM  = 600,
  parameter int DB_PER_NOM  = 2400,
  parameter int TOL_SB_N    = 200,
  parameter int TOL_RISE_N  = 200,
  parameter int TOL_FALL_N  = 350,
  parameter int TOL_SB_E    = 400,
  parameter int TOL_RISE_E  = 300,
  parameter int TOL_FALL_E  = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ext_tol_i,
  output win_t win_o
);
  localparam int NSETS = 2;

  win_t set_w [NSETS];
  logic ext_q;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    localparam int TSB = (g == 0) ? TOL_SB_N   : TOL_SB_E;
    localparam int TRI = (g == 0) ? TOL_RISE_N : TOL_RISE_E;
    localparam int TFA = (g == 0) ? TOL_FALL_N : TOL_FALL_E;
    assign set_w[g] = make_win(SB_LOW_NOM, SB_PER_NOM, D0_LOW_NOM, D1_LOW_NOM,
                               DB_PER_NOM, TSB, TRI, TFA);
  end

  // selection frozen while receiving
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ext_q <= 1'b0;
    else if (!en_i) ext_q <= ext_tol_i;
  end

  assign win_o = set_w[ext_q];
endmodule

// File: rtl/cec_rxt_timer.sv
module cec_rxt_timer
  import cec_rxt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  line_i,
  output logic  fall_o,
  output logic  rise_o,
  output tick_t cnt_o
);
  logic  line_q;
  tick_t cnt_q;

  assign fall_o = line_q & ~line_i;
  assign rise_o = ~line_q & line_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      line_q <= line_i;
      if (fall_o)                    cnt_q <= '0;
      else if (tick_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cec_rxt_fsm.sv
module cec_rxt_fsm
  import cec_rxt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  line_i,
  input  logic  fall_i,
  input  logic  rise_i,
  input  tick_t cnt_i,
  input  win_t  win_i,
  input  logic  stop_on_bre_i,
  input  logic  last_bit_i,
  output ev_t   ev_d_o,
  output ev_t   ev_q_o
);
  st_e  st_q, st_d;
  ev_t  ev_d, ev_q;
  logic bre_seen_q, bre_seen_d;

  always_comb begin
    st_d       = st_q;
    ev_d       = '0;
    bre_seen_d = bre_seen_q;
    if (!en_i) begin
      st_d       = ST_IDLE;
      bre_seen_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (fall_i) st_d = ST_SB_LOW;
        ST_SB_LOW: begin
          if (rise_i)
            st_d = in_win(cnt_i, win_i.sb_low_lo, win_i.sb_low_hi) ? ST_SB_HIGH : ST_IDLE;
          else if (cnt_i > win_i.sb_low_hi)
            st_d = ST_WAIT_HIGH;
        end
        ST_SB_HIGH: begin
          if (fall_i) begin
            if (cnt_i >= win_i.sb_per_lo) begin
              ev_d.sof   = 1'b1;
              st_d       = ST_DB_LOW;
              bre_seen_d = 1'b0;
            end else begin
              st_d = ST_SB_LOW;  // too short: restart as new start candidate
            end
          end else if (cnt_i > win_i.sb_per_hi) begin
            st_d = ST_IDLE;
          end
        end
        ST_DB_LOW: begin
          if (rise_i) begin
            if (bre_seen_q) begin
              st_d       = ST_DB_HIGH;
              bre_seen_d = 1'b0;
            end else if (in_win(cnt_i, win_i.d0_lo, win_i.d0_hi)) begin
              ev_d.bitv = 1'b1;
              st_d      = ST_DB_HIGH;
            end else if (in_win(cnt_i, win_i.d1_lo, win_i.d1_hi)) begin
              ev_d.bitv   = 1'b1;
              ev_d.bitval = 1'b1;
              st_d        = ST_DB_HIGH;
            end else begin
              ev_d.bre = 1'b1;
              if (stop_on_bre_i) begin
                ev_d.stop = 1'b1;
                st_d      = ST_IDLE;
              end else begin
                st_d = ST_DB_HIGH;
              end
            end
          end else if (!bre_seen_q && cnt_i > win_i.d0_hi) begin
            // stuck low: flag before the rise shows up
            ev_d.bre = 1'b1;
            if (stop_on_bre_i) begin
              ev_d.stop = 1'b1;
              st_d      = ST_WAIT_HIGH;
            end else begin
              bre_seen_d = 1'b1;
            end
          end
        end
        ST_DB_HIGH: begin
          if (fall_i) begin
            st_d = (cnt_i >= win_i.per_lo) ? ST_DB_LOW : ST_SB_LOW;
          end else if (cnt_i > win_i.per_hi) begin
            ev_d.lbpe = ~last_bit_i;
            st_d      = ST_IDLE;
          end
        end
        ST_WAIT_HIGH: if (line_i) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ev_q       <= '0;
      bre_seen_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      ev_q       <= ev_d;
      bre_seen_q <= bre_seen_d;
    end
  end

  assign ev_d_o = ev_d;
  assign ev_q_o = ev_q;
endmodule

// File: rtl/cec_rxt_errpol.sv
module cec_rxt_errpol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bre_i,
  input  logic lbpe_i,
  input  logic stop_on_bre_i,
  input  logic bre_gen_i,
  input  logic lbpe_gen_i,
  input  logic bcast_nogen_i,
  input  logic bcast_i,
  output logic err_o
);
  logic req_uni, req_bc, req;

  assign req_uni = (bre_i & bre_gen_i) | (lbpe_i & lbpe_gen_i);
  assign req_bc  = ~bcast_nogen_i & (lbpe_i | (bre_i & (bre_gen_i | stop_on_bre_i)));
  assign req     = bcast_i ? req_bc : req_uni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= req;
  end
endmodule

// File: rtl/cec_rx_bit_timing.sv
module cec_rx_bit_timing
  import cec_rxt_pkg::*;
#(
  parameter int SB_LOW_NOM  = 3700,
  parameter int SB_PER_NOM  = 4500,
  parameter int D0_LOW_NOM  = 1500,
  parameter int D1_LOW_NOM  = 600,
  parameter int DB_PER_NOM  = 2400,
  parameter int TOL_SB_N    = 200,
  parameter int TOL_RISE_N  = 200,
  parameter int TOL_FALL_N  = 350,
  parameter int TOL_SB_E    = 400,
  parameter int TOL_RISE_E  = 300,
  parameter int TOL_FALL_E  = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic line_i,
  input  logic ext_tol_i,
  input  logic stop_on_bre_i,
  input  logic bre_gen_i,
  input  logic lbpe_gen_i,
  input  logic bcast_nogen_i,
  input  logic bcast_i,
  input  logic last_bit_i,
  output logic sof_o,
  output logic bit_valid_o,
  output logic bit_o,
  output logic bre_o,
  output logic lbpe_o,
  output logic stop_rx_o,
  output logic err_req_o
);
  win_t  win;
  tick_t cnt;
  logic  fall, rise;
  ev_t   ev_d, ev_q;

  cec_rxt_win #(
    .SB_LOW_NOM(SB_LOW_NOM), .SB_PER_NOM(SB_PER_NOM), .D0_LOW_NOM(D0_LOW_NOM),
    .D1_LOW_NOM(D1_LOW_NOM), .DB_PER_NOM(DB_PER_NOM),
    .TOL_SB_N(TOL_SB_N), .TOL_RISE_N(TOL_RISE_N), .TOL_FALL_N(TOL_FALL_N),
    .TOL_SB_E(TOL_SB_E), .TOL_RISE_E(TOL_RISE_E), .TOL_FALL_E(TOL_FALL_E)
  ) u_win (
    .clk_i, .rst_ni, .en_i, .ext_tol_i, .win_o(win)
  );

  cec_rxt_timer u_timer (
    .clk_i, .rst_ni, .tick_i, .line_i, .fall_o(fall), .rise_o(rise), .cnt_o(cnt)
  );

  cec_rxt_fsm u_fsm (
    .clk_i, .rst_ni, .en_i, .line_i, .fall_i(fall), .rise_i(rise), .cnt_i(cnt),
    .win_i(win), .stop_on_bre_i, .last_bit_i, .ev_d_o(ev_d), .ev_q_o(ev_q)
  );

  cec_rxt_errpol u_err (
    .clk_i, .rst_ni, .bre_i(ev_d.bre), .lbpe_i(ev_d.lbpe), .stop_on_bre_i,
    .bre_gen_i, .lbpe_gen_i, .bcast_nogen_i, .bcast_i, .err_o(err_req_o)
  );

  assign sof_o       = ev_q.sof;
  assign bit_valid_o = ev_q.bitv;
  assign bit_o       = ev_q.bitval;
  assign bre_o       = ev_q.bre;
  assign lbpe_o      = ev_q.lbpe;
  assign stop_rx_o   = ev_q.stop;
endmodule

// File: rtl/cec_rx_bit_timing_chk.sv
module cec_rx_bit_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic stop_on_bre_i,
  input logic bcast_nogen_i,
  input logic bcast_i,
  input logic sof_o,
  input logic bit_valid_o,
  input logic bit_o,
  input logic bre_o,
  input logic lbpe_o,
  input logic stop_rx_o,
  input logic err_req_o
);
  logic any_out;
  assign any_out = sof_o | bit_valid_o | bit_o | bre_o | lbpe_o | stop_rx_o | err_req_o;

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_req_o |-> (bre_o || lbpe_o)); // R8
  AST_STOP_WITH_BRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_rx_o |-> (bre_o && $past(stop_on_bre_i))); // R4
  AST_BIT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> bit_valid_o); // R2
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sof_o, bit_valid_o, bre_o, lbpe_o})); // R11
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !any_out); // R11
  AST_BCAST_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bre_o || lbpe_o) && $past(bcast_i && bcast_nogen_i)) |-> !err_req_o); // R10
  AST_BCAST_LBPE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbpe_o && $past(bcast_i && !bcast_nogen_i)) |-> err_req_o); // R9
endmodule

bind cec_rx_bit_timing cec_rx_bit_timing_chk u_chk (.*);

// File: tb/tb_cec_rx_bit_timing.sv
module tb_cec_rx_bit_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, tick = 1'b0, line = 1'b1, ext_tol = 1'b0;
  logic stop_bre = 1'b0, bre_gen = 1'b0, lbpe_gen = 1'b0;
  logic bc_nogen = 1'b0, bcast = 1'b0, last_bit = 1'b0;
  logic sof, bitv, bitval, bre, lbpe, stop_rx, err_req;

  int compared = 0, mismatched = 0;
  logic [4:0] tdiv = '0;

  // {sof, bitv, bitval, bre, lbpe, stop, err}
  localparam logic [6:0] E_SOF = 7'b1000000;
  localparam logic [6:0] E_B0  = 7'b0100000;
  localparam logic [6:0] E_B1  = 7'b0110000;
  localparam logic [6:0] E_BRE = 7'b0001000;
  localparam logic [6:0] E_LBP = 7'b0000100;
  localparam logic [6:0] E_STP = 7'b0000010;
  localparam logic [6:0] E_ERR = 7'b0000001;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  cec_rx_bit_timing dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .line_i(line),
    .ext_tol_i(ext_tol), .stop_on_bre_i(stop_bre), .bre_gen_i(bre_gen),
    .lbpe_gen_i(lbpe_gen), .bcast_nogen_i(bc_nogen), .bcast_i(bcast),
    .last_bit_i(last_bit), .sof_o(sof), .bit_valid_o(bitv), .bit_o(bitval),
    .bre_o(bre), .lbpe_o(lbpe), .stop_rx_o(stop_rx), .err_req_o(err_req)
  );

  // microsecond tick: high except one cycle in 32
  always @(negedge clk) begin
    tdiv <= tdiv + 1'b1;
    tick <= (tdiv != 5'd31);
  end

  // monitor
  always @(negedge clk) begin
    logic [6:0] act;
    act = {sof, bitv, bitval, bre, lbpe, stop_rx, err_req};
    if (rst_n && act != '0) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R11 unexpected event actual=%b expected=none", act);
      end else begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          mismatched++;
          $display("FAIL %s actual=%b expected=%b", t, act, e);
        end
      end
    end
  end

  task automatic expect_ev(logic [6:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic tk(int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick) c++;
    end
    @(negedge clk);
  endtask

  task automatic lo_hi(int low, int total);
    line = 1'b0;
    tk(low);
    line = 1'b1;
    tk(total - low);
  endtask

  task automatic settle(int n, string t);
    last_bit = 1'b1;
    tk(n);
    last_bit = 1'b0;
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL %s missing events actual=%0d expected=0", t, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic cfg(logic s, logic bg, logic lg, logic bn, logic bc);
    stop_bre = s; bre_gen = bg; lbpe_gen = lg; bc_nogen = bn; bcast = bc;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if ({sof, bitv, bitval, bre, lbpe, stop_rx, err_req} !== 7'b0) begin
      mismatched++;
      $display("FAIL R12 reset outputs actual=%b expected=0", {sof, bitv, bitval, bre, lbpe, stop_rx, err_req});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    en = 1'b1;
    tk(10);

    // R1 R2 nominal message with quiet end on last bit; R12 normal set after reset
    expect_ev(E_SOF, "R1 start accepted");
    lo_hi(3700, 4500);
    expect_ev(E_B0, "R2 bit 0");
    lo_hi(1500, 2400);
    expect_ev(E_B1, "R2 bit 1");
    lo_hi(600, 2400);
    expect_ev(E_B1, "R5 last bit");
    last_bit = 1'b1;
    lo_hi(600, 2400);
    settle(800, "R5 last bit quiet end");

    // R1 invalid start ignored, then a valid one
    lo_hi(3300, 4500);
    settle(100, "R1 short start ignored");
    expect_ev(E_SOF, "R1 start after reject");
    lo_hi(3700, 4500);
    expect_ev(E_B1, "R2 bit 1 after reject");
    lo_hi(600, 2400);
    settle(800, "R1 tail");

    // R3 R8 rising error, no stop, decoding continues
    cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_ev(E_SOF, "R1 start");
    lo_hi(3700, 4500);
    expect_ev(E_BRE | E_ERR, "R3 R8 rise between windows");
    lo_hi(1000, 2400);
    expect_ev(E_B0, "R4 decoding continues");
    lo_hi(1500, 2400);
    settle(800, "R3 tail");

    // R4 stop on rising error, message ends
    cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_ev(E_SOF, "R1 start");
    lo_hi(3700, 4500);
    expect_ev(E_BRE | E_STP, "R4 R8 stop without error bit");
    lo_hi(1000, 2400);
    lo_hi(1500, 2400);
    settle(2800, "R4 next bit not decoded");

    // R5 R8 long period, non-broadcast, enabled
    cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_ev(E_SOF, "R1 start");
    lo_hi(3700, 4500);
    expect_ev(E_B0, "R2 bit 0");
    expect_ev(E_LBP | E_ERR, "R5 R8 long period with error bit");
    lo_hi(1500, 2400);
    tk(500);
    settle(10, "R5 tail");

    // R9 broadcast, long period forces error bit
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_ev(E_SOF, "R1 start");
    lo_hi(3700, 4500);
    expect_ev(E_B1, "R2 bit 1");
    expect_ev(E_LBP | E_ERR, "R9 broadcast long period");
    lo_hi(600, 2400);
    tk(500);
    settle(10, "R9 tail");

    // R9 broadcast, rising error with stop forces error bit
    cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_ev(E_SOF, "R1 start");
    lo_hi(3700, 4500);
    expect_ev(E_BRE | E_STP | E_ERR, "R9 broadcast rise error with stop");
    lo_hi(1000, 2400);
    settle(800, "R9 tail 2");

    // R10 broadcast suppression
    cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    expect_ev(E_SOF, "R1 start");
    lo_hi(3700, 4500);
    expect_ev(E_BRE, "R10 rise error suppressed");
    lo_hi(1000, 2400);
    expect_ev(E_B1, "R2 bit 1");
    expect_ev(E_LBP, "R10 long period suppressed");
    lo_hi(600, 2400);
    tk(500);
    settle(10, "R10 tail");

    // R3 line stuck low, with stop
    cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_ev(E_SOF, "R1 start");
    lo_hi(3700, 4500);
    expect_ev(E_BRE | E_STP | E_ERR, "R3 stuck low");
    lo_hi(2000, 2400);
    settle(2800, "R3 stuck low single event");

    // R6 extended windows
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    en = 1'b0; ext_tol = 1'b1; tk(5); en = 1'b1; tk(5);
    expect_ev(E_SOF, "R6 extended start");
    lo_hi(3350, 4500);
    expect_ev(E_B0, "R6 extended bit 0");
    lo_hi(1250, 2850);
    expect_ev(E_B1, "R6 extended bit 1");
    lo_hi(350, 2400);
    settle(800, "R6 tail");

    // R7 selection change while enabled is ignored
    ext_tol = 1'b0; tk(5);
    expect_ev(E_SOF, "R7 still extended");
    lo_hi(3350, 4500);
    expect_ev(E_B1, "R7 bit 1");
    lo_hi(600, 2400);
    settle(800, "R7 tail");
    en = 1'b0; tk(5); en = 1'b1; tk(5);
    lo_hi(3350, 4500);
    settle(100, "R7 normal after disable");

    // R11 disabled: nothing reported
    en = 1'b0;
    lo_hi(3700, 4500);
    lo_hi(1500, 2400);
    settle(800, "R11 disabled quiet");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule